// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block counts processor activity for profiling. It holds one cycle counter and two event counters, all 32 bits wide. Each event counter is tied to one line of a 256-line strobe bus through an 8-bit event code: while counting is enabled, the counter advances on every clock in which the strobe line picked by its code is high. The cycle counter advances on every clock, or once every 64 clocks when the prescale option is on.

Software reaches the block through a four-register read/write port: a packed control word and the three counters. The control word holds the global enable, one-shot counter resets, the prescale option, three interrupt enables, three sticky overflow flags and the two event codes. A counter that wraps from all ones to zero sets its overflow flag. Software clears a flag by writing a one back to it. A level interrupt is raised while any flag is set together with its enable.

Top module: `evt_perf_monitor`

## Requirements
- R1: While control bit 0 (enable) is 0, no counter changes value, except through a register write or a reset bit.
- R2: Writing a control word with bit 1 set zeroes both event counters. Writing one with bit 2 set zeroes the cycle counter. Each reset leaves the other counter group untouched.
- R3: With control bit 3 set and enable set, the cycle counter advances once every 64 clocks. The 64-clock phase restarts when the cycle counter is reset.
- R4: Event counter 0 uses the code in control bits 19:12, and event counter 1 uses the code in bits 27:20. A counter advances by one on each enabled clock in which the strobe line at index equal to its code is high.
- R5: An event code of 0xFF never advances its counter, whatever the strobe bus carries.
- R6: A counter that advances from 0xFFFFFFFF goes to 0 and sets its overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter.
- R7: A control write with a 1 in a flag bit clears that flag. A 0 in a flag bit leaves the flag as it was.
- R8: If a counter wraps in the same clock as a write that clears its flag, the flag stays set.
- R9: irqOut is high exactly while some overflow flag and its interrupt enable are both set. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R10: Control bits 7, 11 and 31:28 are stored as zero on every write. The reset bits 1 and 2 always read back as zero.
- R11: Address 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A write to a counter address loads that value, and a read returns the current value.
- R12: After reset, all four registers read zero and irqOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 2 | Register address for both read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| evtStrobe | input | 256 | One event strobe per event code |
| irqOut | output | 1 | Level interrupt request |

## Verification
The properties assume that register writes are single-clock pulses with a stable address and data. They also assume that no counter load and no control write fall in the clock in which a wrap property is armed. The directed stimulus changes inputs only on the falling edge and holds each write for exactly one rising edge. Wraps are made to land in clocks without a write, except in the one scenario that deliberately collides a flag clear with an overflow.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  // control word bit positions (fixed: software decodes them)
  localparam int BIT_EN      = 0;
  localparam int BIT_CLR_EVT = 1;
  localparam int BIT_CLR_CYC = 2;
  localparam int BIT_DIV     = 3;
  localparam int IE_LO       = 4;   // ev0, ev1, cyc
  localparam int OF_LO       = 8;   // ev0, ev1, cyc
  localparam int SEL0_LO     = 12;
  localparam int SEL1_LO     = 20;
  localparam int SEL_W       = 8;
  localparam int NUM_CODES   = 1 << SEL_W;
  localparam int NUM_CNT     = 3;   // index 0,1 event, 2 cycle
  localparam logic [SEL_W-1:0] CODE_IDLE = '1;

  typedef struct packed {
    logic [NUM_CNT-1:0] clr;
    logic [NUM_CNT-1:0] ld;
    logic [NUM_CNT-1:0] inc;
  } pmuStrobe_t;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ldVal,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  // priority: clear, then load, then increment
  assign wrap = inc && !clr && !ld && (&cnt);

  always_ff @(posedge clk) begin
    if (!rstN)      cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (ld)    cnt <= ldVal;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pmuStrobe_t                    stb,
  input  logic [CNT_W-1:0]              wrData,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVec,
  output logic [NUM_CNT-1:0]            wrapVec
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (stb.clr[i]),
      .ld    (stb.ld[i]),
      .ldVal (wrData),
      .inc   (stb.inc[i]),
      .cnt   (cntVec[i]),
      .wrap  (wrapVec[i])
    );
  end
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int DIV_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           addr,
  input  logic [31:0]          wrData,
  input  logic [NUM_CODES-1:0] evtStrobe,
  input  logic [NUM_CNT-1:0]   wrapVec,
  output pmuStrobe_t           stb,
  output logic [31:0]          ctrlWord,
  output logic                 irqOut
);
  logic                       enReg;
  logic                       divMode;
  logic [NUM_CNT-1:0]         ieVec;
  logic [NUM_CNT-1:0]         ofVec;
  logic [1:0][SEL_W-1:0]      selVec;
  logic [DIV_LOG2-1:0]        divCnt;
  logic                       ctlWrite;
  logic [NUM_CNT-1:0]         ofClr;
  logic                       unusedBits;

  assign ctlWrite   = wrEn && (addr == 2'd0);
  assign ofClr      = ctlWrite ? wrData[OF_LO +: NUM_CNT] : '0;
  assign unusedBits = ^{wrData[31:28], wrData[11], wrData[7]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      divMode <= 1'b0;
      ieVec   <= '0;
      ofVec   <= '0;
      selVec  <= '0;
    end else begin
      if (ctlWrite) begin
        enReg     <= wrData[BIT_EN];
        divMode   <= wrData[BIT_DIV];
        ieVec     <= wrData[IE_LO +: NUM_CNT];
        selVec[0] <= wrData[SEL0_LO +: SEL_W];
        selVec[1] <= wrData[SEL1_LO +: SEL_W];
      end
      // a fresh wrap beats a clear in the same clock
      ofVec <= (ofVec & ~ofClr) | wrapVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 divCnt <= '0;
    else if (stb.clr[2])       divCnt <= '0;
    else if (enReg && divMode) divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    stb.clr[0] = ctlWrite && wrData[BIT_CLR_EVT];
    stb.clr[1] = ctlWrite && wrData[BIT_CLR_EVT];
    stb.clr[2] = ctlWrite && wrData[BIT_CLR_CYC];
    stb.ld[0]  = wrEn && (addr == 2'd2);
    stb.ld[1]  = wrEn && (addr == 2'd3);
    stb.ld[2]  = wrEn && (addr == 2'd1);
    stb.inc[2] = enReg && (!divMode || (&divCnt));
  end

  for (genvar i = 0; i < 2; i++) begin : g_evt
    assign stb.inc[i] = enReg && (selVec[i] != CODE_IDLE) && evtStrobe[selVec[i]];
  end

  always_comb begin
    ctrlWord                      = '0;
    ctrlWord[BIT_EN]              = enReg;
    ctrlWord[BIT_DIV]             = divMode;
    ctrlWord[IE_LO +: NUM_CNT]    = ieVec;
    ctrlWord[OF_LO +: NUM_CNT]    = ofVec;
    ctrlWord[SEL0_LO +: SEL_W]    = selVec[0];
    ctrlWord[SEL1_LO +: SEL_W]    = selVec[1];
  end

  assign irqOut = |(ofVec & ieVec);
endmodule

// File: rtl/evt_perf_monitor.sv
module evt_perf_monitor
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_CODES-1:0] evtStrobe,
  output logic                 irqOut
);
  localparam int DATA_W = 32;

  pmuStrobe_t                    stb;
  logic [DATA_W-1:0]             ctrlWord;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVec;
  logic [NUM_CNT-1:0]            wrapVec;

  pmu_ctrl #(.DIV_LOG2(DIV_LOG2)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (regWrEn),
    .addr      (regAddr),
    .wrData    (regWrData),
    .evtStrobe (evtStrobe),
    .wrapVec   (wrapVec),
    .stb       (stb),
    .ctrlWord  (ctrlWord),
    .irqOut    (irqOut)
  );

  pmu_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (regWrData[CNT_W-1:0]),
    .cntVec  (cntVec),
    .wrapVec (wrapVec)
  );

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = ctrlWord;
      2'd1:    regRdData = DATA_W'(cntVec[2]);
      2'd2:    regRdData = DATA_W'(cntVec[0]);
      default: regRdData = DATA_W'(cntVec[1]);
    endcase
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       addr,
  input logic [31:0]      wrData,
  input logic [31:0]      ctrlWord,
  input logic [CNT_W-1:0] cycCnt,
  input logic [CNT_W-1:0] ev0Cnt,
  input logic [CNT_W-1:0] ev1Cnt,
  input logic             irqOut
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWord[0] && !wrEn) |=> ($stable(cycCnt) && $stable(ev0Cnt) && $stable(ev1Cnt)));

  assert_cyc_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0 && wrData[2]) |=> (cycCnt == '0));

  assert_evt_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0 && wrData[1]) |=> (ev0Cnt == '0 && ev1Cnt == '0));

  assert_idle_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[19:12] == 8'hFF && !wrEn) |=> $stable(ev0Cnt));

  assert_wrap_ev0_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ev0Cnt == CMAX && !wrEn) |=> (ev0Cnt == CMAX || ctrlWord[8]));

  assert_wrap_cyc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cycCnt == CMAX && !wrEn) |=> (cycCnt == CMAX || ctrlWord[10]));

  assert_flag_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0 && !wrData[8] && ctrlWord[8]) |=> ctrlWord[8]);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(ctrlWord[10:8] & ctrlWord[6:4]));

  assert_zero_bits_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[31:28] == 4'd0 && !ctrlWord[11] && !ctrlWord[7] && ctrlWord[2:1] == 2'd0));
endmodule

bind evt_perf_monitor pmu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (regWrEn),
  .addr     (regAddr),
  .wrData   (regWrData),
  .ctrlWord (ctrlWord),
  .cycCnt   (cntVec[2]),
  .ev0Cnt   (cntVec[0]),
  .ev1Cnt   (cntVec[1]),
  .irqOut   (irqOut)
);

// File: tb/sim_evt_perf_monitor.sv
module sim_evt_perf_monitor;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic [255:0] evtStrobe = '0;
  logic         irqOut;
  int           tests = 0;
  int           fails = 0;

  evt_perf_monitor u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .evtStrobe(evtStrobe), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [31:0] EN = 32'h1, CLRE = 32'h2, CLRC = 32'h4, DIV = 32'h8;
  localparam logic [31:0] IE0 = 32'h10, IE1 = 32'h20, IEC = 32'h40;
  localparam logic [31:0] OF0 = 32'h100, OF1 = 32'h200, OFC = 32'h400;

  function automatic logic [31:0] sel(input logic [7:0] c0, input logic [7:0] c1);
    return {4'd0, c1, c0, 12'd0};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    tests++;
    if (regRdData !== exp) begin
      fails++;
      $display("FAIL %s: addr %0d actual %h expected %h", tag, a, regRdData, exp);
    end
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    tests++;
    if (irqOut !== exp) begin
      fails++;
      $display("FAIL %s: irqOut actual %b expected %b", tag, irqOut, exp);
    end
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    evtStrobe = '0; evtStrobe[idx] = 1'b1;
    @(negedge clk);
    evtStrobe = '0;
  endtask

  task automatic t_reset_R12;
    chk(2'd0, 32'h0, "R12 ctrl"); chk(2'd1, 32'h0, "R12 cyc");
    chk(2'd2, 32'h0, "R12 ev0");  chk(2'd3, 32'h0, "R12 ev1");
    chkIrq(1'b0, "R12 irq");
  endtask

  task automatic t_zero_bits_R10;
    wr(2'd0, 32'hFFFF_FFFF);
    chk(2'd0, 32'h0FFF_F079, "R10 masked readback");
    wr(2'd0, 32'h0);
    chk(2'd0, 32'h0, "R10 cleared");
  endtask

  task automatic t_load_R11;
    wr(2'd1, 32'h0000_1234); wr(2'd2, 32'hA5A5_0001); wr(2'd3, 32'h0BAD_F00D);
    repeat (10) @(negedge clk);
    chk(2'd1, 32'h0000_1234, "R11/R1 cyc load held");
    chk(2'd2, 32'hA5A5_0001, "R11/R1 ev0 load held");
    chk(2'd3, 32'h0BAD_F00D, "R11/R1 ev1 load held");
  endtask

  task automatic t_cycle_R1;
    wr(2'd0, EN | CLRC);
    repeat (8) @(negedge clk);
    wr(2'd0, 32'h0);
    chk(2'd1, 32'd10, "R1 cycle count while enabled");
    repeat (5) @(negedge clk);
    chk(2'd1, 32'd10, "R1 cycle frozen when disabled");
  endtask

  task automatic t_prescale_R3;
    wr(2'd0, EN | DIV | CLRC);
    repeat (128) @(negedge clk);
    wr(2'd0, 32'h0);
    chk(2'd1, 32'd2, "R3 prescaled cycle count");
  endtask

  task automatic t_events_R4;
    wr(2'd0, EN | CLRE | sel(8'h05, 8'h22));
    pulse(5); pulse(8'h22); pulse(5); pulse(7); pulse(8'h22); pulse(5);
    chk(2'd2, 32'd3, "R4 ev0 code 0x05");
    chk(2'd3, 32'd2, "R4 ev1 code 0x22");
    wr(2'd0, 32'h0);
  endtask

  task automatic t_clear_R2;
    wr(2'd1, 32'h55);
    wr(2'd0, CLRE);
    chk(2'd2, 32'd0, "R2 ev0 reset"); chk(2'd3, 32'd0, "R2 ev1 reset");
    chk(2'd1, 32'h55, "R2 cyc untouched by event reset");
    wr(2'd2, 32'h77);
    wr(2'd0, CLRC);
    chk(2'd1, 32'd0, "R2 cyc reset");
    chk(2'd2, 32'h77, "R2 ev0 untouched by cycle reset");
  endtask

  task automatic t_unused_R5;
    wr(2'd2, 32'h0); wr(2'd3, 32'h0);
    wr(2'd0, EN | sel(8'hFF, 8'h10));
    @(negedge clk); evtStrobe = '1;
    repeat (5) @(negedge clk);
    evtStrobe = '0;
    chk(2'd2, 32'd0, "R5 code 0xFF never counts");
    chk(2'd3, 32'd5, "R5 neighbour with code 0x10 counts");
    wr(2'd0, 32'h0);
  endtask

  task automatic t_wrap_R6_R7_R9;
    logic [31:0] base;
    base = EN | IE0 | sel(8'h01, 8'hFF);
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd0, base);
    pulse(1); pulse(1);
    chk(2'd2, 32'd0, "R6 ev0 wraps to zero");
    chk(2'd0, base | OF0, "R6 ev0 flag set");
    chkIrq(1'b1, "R9 irq with flag and enable");
    wr(2'd0, base);
    chk(2'd0, base | OF0, "R7 zero write keeps flag");
    wr(2'd0, base | OF0);
    chk(2'd0, base, "R7 one write clears flag");
    chkIrq(1'b0, "R9 irq low after clear");
    base = EN | sel(8'h01, 8'hFF);
    wr(2'd0, base);
    wr(2'd2, 32'hFFFF_FFFF);
    pulse(1);
    chk(2'd0, base | OF0, "R6 flag set without enable");
    chkIrq(1'b0, "R9 irq masked by disabled enable");
    wr(2'd0, OF0);
  endtask

  task automatic t_collide_R8;
    logic [31:0] base;
    base = EN | IE1 | sel(8'hFF, 8'h02);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, base);
    @(negedge clk);
    evtStrobe = '0; evtStrobe[2] = 1'b1;
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = base | OF1;
    @(negedge clk);
    evtStrobe = '0; regWrEn = 1'b0;
    chk(2'd3, 32'd0, "R8 ev1 wrapped");
    chk(2'd0, base | OF1, "R8 overflow beats clear");
    chkIrq(1'b1, "R8 irq held");
    wr(2'd0, OF1);
    chk(2'd0, 32'h0, "R7 flag cleared afterwards");
  endtask

  task automatic t_cyc_wrap_R6;
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd0, EN | IEC);
    wr(2'd0, IEC);
    chk(2'd1, 32'd1, "R6 cycle wrapped then advanced");
    chk(2'd0, IEC | OFC, "R6 cycle flag set");
    chkIrq(1'b1, "R9 irq from cycle flag");
    wr(2'd0, OFC);
    chk(2'd0, 32'h0, "R7 cycle flag cleared");
    chkIrq(1'b0, "R9 irq low");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_R12();
    t_zero_bits_R10();
    t_load_R11();
    t_cycle_R1();
    t_prescale_R3();
    t_events_R4();
    t_clear_R2();
    t_unused_R5();
    t_wrap_R6_R7_R9();
    t_collide_R8();
    t_cyc_wrap_R6();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule